// File: doc/BRIEF.md
# SCL Waveform Timing Generator

This block produces the clock line of an I2C master from programmable cycle counts. All counts are in cycles of the block clock, which is meant to run at 24 MHz, so one count step is about 41.7 ns. Each low phase of SCL lasts its programmed count plus a fixed overhead of 2 cycles. Each high phase lasts its programmed count plus a fixed overhead of 7 cycles. Within each phase, a programmable offset places a one-cycle strobe. The strobe in the low phase tells a data path when to change SDA. The strobe in the high phase tells it when to sample SDA.

A start request makes the block hold SCL released for a lead-in time while the data path pulls SDA low. The first low phase follows. A stop request ends the run at the end of the current high phase. After that, SCL stays released for a bus-free interval, and new start requests are refused until that interval has expired. New timing words take effect only when a low phase begins, or when a start is accepted.

The three timing words are laid out as follows:
- timing0 carries the high count in bits 25:16 and the receive offset in bits 9:0.
- timing1 carries the low count in bits 25:16 and the transmit offset in bits 9:0.
- timing2 carries the bus-free count in bits 31:16 and the lead-in count in bits 15:0.

Bits 31:26 and 15:10 of timing0 and timing1 are reserved and unused.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset, scl_drive_low, tx_strobe, rx_strobe and busy are all 0.
- R2: Each low phase drives scl_drive_low to 1 for exactly timing1[25:16] + 2 consecutive cycles.
- R3: Each high phase releases SCL (scl_drive_low = 0) for exactly timing0[25:16] + 7 cycles before the next low phase.
- R4: With both counts set to 1, the SCL period is 11 cycles: 3 cycles low and 8 cycles high.
- R5: tx_strobe is high for one cycle in each low phase, in the cycle after timing1[9:0] cycles of that phase have elapsed (an offset of 0 means the first low cycle). It never fires if the offset is not less than the phase length.
- R6: rx_strobe behaves the same way in each high phase, using timing0[9:0].
- R7: When start_req is high with enable set while the block is idle, busy rises on the next cycle. SCL then stays released for max(timing2[15:0], 1) cycles, and the first low phase follows.
- R8: A stop_req during a run, including one on the final high cycle, ends the run at the end of the current high phase. SCL then stays released with busy high for max(timing2[31:16], 1) cycles, and busy then falls.
- R9: A start_req while busy is high, including during the bus-free interval, is ignored, so busy is 0 in the cycle after the interval ends.
- R10: Timing words are captured only when a start is accepted and when a low phase begins. A change in the middle of a phase does not alter that phase or the high phase that follows it.
- R11: When enable is low, the block returns to idle on the next cycle, with SCL released and busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (24 MHz intended) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable; low forces idle |
| timing0 | input | 32 | High count [25:16], receive offset [9:0] |
| timing1 | input | 32 | Low count [25:16], transmit offset [9:0] |
| timing2 | input | 32 | Bus-free count [31:16], lead-in count [15:0] |
| start_req | input | 1 | Request a start condition |
| stop_req | input | 1 | Request a stop after the current high phase |
| scl_drive_low | output | 1 | 1 pulls SCL low (open drain), 0 releases it |
| tx_strobe | output | 1 | One-cycle strobe for changing SDA |
| rx_strobe | output | 1 | One-cycle strobe for sampling SDA |
| busy | output | 1 | High from start acceptance to the end of bus-free |

## Verification
Two collisions matter here. The first is a stop request arriving in the very cycle that a high phase ends. The second is a start request present in the cycle that the bus-free interval expires. The bench uses its reference model's phase position to raise stop_req exactly on the final high cycle, and checks that the run goes straight into bus-free with no extra low phase. It then holds start_req high through the whole bus-free interval, and checks that busy is 0 in the cycle after the interval ends. A per-cycle comparison against the model judges both collisions, and so do directed checks on the measured bus-free length.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CW = 10,
  parameter int GW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [31:0] timing0,
  input  logic [31:0] timing1,
  input  logic [31:0] timing2,
  input  logic        start_req,
  input  logic        stop_req,
  output logic        scl_drive_low,
  output logic        tx_strobe,
  output logic        rx_strobe,
  output logic        busy
);
  localparam int FLD = 16;
  localparam logic [GW-1:0] LOW_EXTRA  = GW'(1);
  localparam logic [GW-1:0] HIGH_EXTRA = GW'(6);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_LOW, S_HIGH, S_FREE} st_t;

  st_t           st;
  logic [GW-1:0] cnt, lim;
  logic [CW-1:0] hi_q, rx_q, lo_q, tx_q;
  logic [GW-1:0] lead_q, free_q;
  logic          pend, phase_end, stop_now;

  always_comb begin
    case (st)
      S_HOLD:  lim = (lead_q == '0) ? '0 : lead_q - GW'(1);
      S_LOW:   lim = GW'(lo_q) + LOW_EXTRA;
      S_HIGH:  lim = GW'(hi_q) + HIGH_EXTRA;
      S_FREE:  lim = (free_q == '0) ? '0 : free_q - GW'(1);
      default: lim = '0;
    endcase
  end

  assign phase_end = (cnt == lim);
  assign stop_now  = pend | stop_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      pend <= 1'b0;
      hi_q <= '0; rx_q <= '0; lo_q <= '0; tx_q <= '0;
      lead_q <= '0; free_q <= '0;
    end else if (!enable) begin
      st <= S_IDLE;
      cnt <= '0;
      pend <= 1'b0;
    end else begin
      cnt <= phase_end ? '0 : cnt + GW'(1);
      if (stop_req && (st inside {S_HOLD, S_LOW, S_HIGH})) pend <= 1'b1;
      if ((st == S_IDLE && start_req) || (st == S_HOLD && phase_end) ||
          (st == S_HIGH && phase_end && !stop_now)) begin
        hi_q   <= timing0[FLD +: CW];
        rx_q   <= timing0[0 +: CW];
        lo_q   <= timing1[FLD +: CW];
        tx_q   <= timing1[0 +: CW];
        lead_q <= timing2[0 +: GW];
        free_q <= timing2[FLD +: GW];
      end
      case (st)
        S_IDLE: if (start_req) st <= S_HOLD;
        S_HOLD: if (phase_end) st <= S_LOW;
        S_LOW:  if (phase_end) st <= S_HIGH;
        S_HIGH: if (phase_end) begin
          if (stop_now) begin
            st <= S_FREE;
            pend <= 1'b0;
          end else st <= S_LOW;
        end
        S_FREE: if (phase_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_drive_low = (st == S_LOW);
  assign tx_strobe     = (st == S_LOW)  && (cnt == GW'(tx_q));
  assign rx_strobe     = (st == S_HIGH) && (cnt == GW'(rx_q));
  assign busy          = (st != S_IDLE);

  a_r5_tx_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> scl_drive_low && busy);

  a_r6_rx_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> !scl_drive_low && busy);

  a_r7_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_req && enable) |=> (busy && !scl_drive_low));

  a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !scl_drive_low));

  a_r10_no_midphase: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOW && $past(st) == S_LOW) |-> ($stable(lo_q) && $stable(tx_q)));

endmodule

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
  logic clk = 0, rst_n = 0, enable = 0, start_req = 0, stop_req = 0;
  logic [31:0] timing0 = 0, timing1 = 0, timing2 = 0;
  logic scl_drive_low, tx_strobe, rx_strobe, busy;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  scl_timing_gen u_dut (.clk, .rst_n, .enable, .timing0, .timing1, .timing2,
    .start_req, .stop_req, .scl_drive_low, .tx_strobe, .rx_strobe, .busy);

  function automatic logic [31:0] word(int c, int off);
    return {6'd0, 10'(c), 6'd0, 10'(off)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase number, cycles elapsed, phase length
  int mph = 0, mel = 0, mlen = 0, mh = 0, mr = 0, ml = 0, mx = 0, mlead = 0, mbf = 0;
  bit mpend = 0;

  function automatic int atleast1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic m_capture();
    mh = int'(timing0[25:16]); mr = int'(timing0[9:0]);
    ml = int'(timing1[25:16]); mx = int'(timing1[9:0]);
    mlead = int'(timing2[15:0]); mbf = int'(timing2[31:16]);
  endtask

  task automatic m_enter_low();
    m_capture();
    mph = 2; mel = 0; mlen = ml + 2;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mel = 0; mpend = 0;
      mh = 0; mr = 0; ml = 0; mx = 0; mlead = 0; mbf = 0;
    end else if (!enable) begin
      mph = 0; mel = 0; mpend = 0;
    end else begin
      if (stop_req && mph >= 1 && mph <= 3) mpend = 1;
      case (mph)
        0: if (start_req) begin m_capture(); mph = 1; mel = 0; mlen = atleast1(mlead); end
        1: begin mel++; if (mel == mlen) m_enter_low(); end
        2: begin mel++; if (mel == mlen) begin mph = 3; mel = 0; mlen = mh + 7; end end
        3: begin
          mel++;
          if (mel == mlen) begin
            if (mpend) begin mph = 4; mel = 0; mlen = atleast1(mbf); mpend = 0; end
            else m_enter_low();
          end
        end
        default: begin mel++; if (mel == mlen) mph = 0; end
      endcase
    end
  end

  // per-cycle compare and run-length monitor
  int run = 0, last_low = 0, last_high = 0;
  bit prev_scl = 0, seen_low = 0;
  always @(negedge clk) begin
    chk(scl_drive_low == (mph == 2), "R2/R3 scl_drive_low", scl_drive_low, mph == 2);
    chk(tx_strobe == (mph == 2 && mel == mx), "R5 tx_strobe", tx_strobe, mph == 2 && mel == mx);
    chk(rx_strobe == (mph == 3 && mel == mr), "R6 rx_strobe", rx_strobe, mph == 3 && mel == mr);
    chk(busy == (mph != 0), "R8 busy", busy, mph != 0);
    if (scl_drive_low == prev_scl) run++;
    else begin
      if (prev_scl) begin last_low = run; seen_low = 1; end
      else if (seen_low) last_high = run;
      run = 1;
    end
    prev_scl = scl_drive_low;
    if (!busy) seen_low = 0;
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl(bit v);
    do @(negedge clk); while (scl_drive_low !== v);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int n;
    logic [31:0] lf;
    cycles(3);
    chk(!scl_drive_low && !tx_strobe && !rx_strobe && !busy, "R1 reset outputs",
        {scl_drive_low, tx_strobe, rx_strobe, busy}, 0);
    rst_n = 1; enable = 1;
    timing0 = word(1, 3); timing1 = word(1, 0); timing2 = {16'd5, 16'd4};
    cycles(2);
    chk(!busy, "R1 idle after reset", busy, 0);

    start_req = 1; @(negedge clk); start_req = 0;
    chk(busy && !scl_drive_low, "R7 start accepted", busy, 1);
    n = 1;
    while (!scl_drive_low) begin @(negedge clk); if (!scl_drive_low) n++; end
    chk(n == 4, "R7 lead-in length", n, 4);
    cycles(40);
    chk(last_low == 3, "R4 low length with count 1", last_low, 3);
    chk(last_high == 8, "R4 high length with count 1", last_high, 8);

    // stop on the final high cycle, start held through bus-free
    do @(negedge clk); while (!(mph == 3 && mel == mlen - 1));
    stop_req = 1; @(negedge clk); stop_req = 0;
    start_req = 1;
    n = 0;
    while (busy) begin
      chk(!scl_drive_low, "R8 no low phase after stop", scl_drive_low, 0);
      n++; @(negedge clk);
    end
    chk(n == 5, "R8 bus-free length", n, 5);
    start_req = 0;
    @(negedge clk);
    chk(!busy, "R9 start during bus-free ignored", busy, 0);

    // longer phases, zero lead-in and bus-free, rx offset out of range
    timing0 = word(15, 30); timing1 = word(20, 5); timing2 = 0;
    start_req = 1; @(negedge clk); start_req = 0;
    wait_scl(1);
    timing0 = word(40, 2);
    wait_scl(0);
    wait_scl(1);
    chk(last_low == 22, "R2 low length 20+2", last_low, 22);
    chk(last_high == 22, "R10 high uses captured count", last_high, 22);
    wait_scl(0);
    wait_scl(1);
    chk(last_high == 47, "R3 high length 40+7", last_high, 47);
    start_req = 1; cycles(3); start_req = 0;
    chk(busy, "R9 start while running ignored", busy, 1);
    stop_req = 1; @(negedge clk); stop_req = 0;
    do @(negedge clk); while (busy);
    chk(!scl_drive_low, "R8 idle after stop", scl_drive_low, 0);

    // enable drop in mid-run
    timing0 = word(3, 1); timing1 = word(2, 1); timing2 = {16'd2, 16'd1};
    start_req = 1; @(negedge clk); start_req = 0;
    wait_scl(1);
    enable = 0; @(negedge clk);
    chk(!busy && !scl_drive_low, "R11 disable forces idle", busy, 0);
    enable = 1; cycles(2);

    // pseudo-random traffic
    lf = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      start_req = lf[3] & lf[7];
      stop_req  = (lf[11:9] == 3'd5);
      enable    = !(lf[19:14] == 6'd0);
      if (lf[25:22] == 4'd9) begin
        timing0 = word(int'(lf[2:0]), int'(lf[6:3]));
        timing1 = word(int'(lf[10:8]), int'(lf[13:11]));
        timing2 = {13'd0, lf[17:15], 13'd0, lf[20:18]};
      end
      @(negedge clk);
    end
    start_req = 0; stop_req = 0; enable = 1;
    cycles(5);
    finish_run();
  end
endmodule